// File: doc/BRIEF.md
# Iterative 512-bit Four-Branch Keyless Permutation

This block applies a fixed, keyless 512-bit permutation to a block of data. The block is viewed as four 128-bit words, named A, B, C and D from the most significant end. Each round updates the four words one after another, each update feeding the next. Every branch function is one AES round whose key addition is replaced by a 128-bit constant that depends on the round number and on which of the four branch functions is used.

The core works one round per clock cycle. Within a cycle, the four branch evaluations are chained combinationally. A caller pulses the start input with the block on the data input while the core is idle. It then waits for the done pulse and reads the permuted block, which stays on the output until the next accepted start. The core is meant to sit under a wide-block encryption or hashing mode that needs the permutation as a primitive.

Top module: `wide_perm_core`

## Requirements
- R1: After a synchronous active-low reset, `busy_o` and `done_o` are 0 and `data_o` is all zeros.
- R2: The result on `data_o` equals 15 rounds of the round function applied to the block captured with the accepted start, where A is bits [511:384], B is [383:256], C is [255:128] and D is [127:0], for both input and output.
- R3: One round with round index r (0 to 14) computes A' = A ^ G2(D), B' = B ^ G3(C ^ G2(D)), C' = C ^ G0(B'), D' = D ^ G1(A ^ G0(B')), all from the same pre-round words.
- R4: Gk(x) = MixColumns(ShiftRows(SubBytes(x))) ^ K(r,k). The byte order of x is column-major with byte 0 in bits [127:120]. SubBytes, ShiftRows and MixColumns are as in AES. Byte j of K(r,k), with byte 0 most significant, is ((16*(4r+k)+j)*0x9D mod 256) XOR 0x5A.
- R5: A start seen while idle is accepted on that rising edge. `busy_o` is then 1 for exactly 15 cycles, and `done_o` is 1 in the cycle after the 16th rising edge, counting the accepting edge as the first.
- R6: `done_o` is high for exactly one cycle per accepted start, and it coincides with `busy_o` being 0.
- R7: A start asserted while `busy_o` is 1 is ignored. The result and the timing of the run in progress do not change.
- R8: Once `done_o` has been raised, `data_o` holds its value until the next accepted start.
- R9: A start asserted in the same cycle as `done_o` is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| data_i | input | 512 | Block to permute, A in the top 128 bits |
| data_o | output | 512 | Current state; the permuted block once done |
| busy_o | output | 1 | A permutation is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench compares each result against an independent model of the round equations. The inputs are all-zero, all-one, structured and pseudo-random blocks. A wrong branch order, swapped word slicing or a wrong constant index would show up as a result mismatch. An off-by-one round count would change both the result and the done latency, so both are checked.

A start injected in the middle of a run must neither reload the state nor reset the counter. A core that restarted would produce the second block's result, or finish late. A start issued in the done cycle must begin a fresh run, so a core that stays busy one cycle too long would lose it. The output is also watched for several idle cycles after done, which catches a state register that keeps stepping.

// File: rtl/wperm_pkg.sv
// Shared constants and AES-round helper functions for the wide permutation.
// Assumes byte 0 of a 128-bit word is bits [127:120], column-major layout.
package wperm_pkg;

    localparam int WORD_W  = 128;
    localparam int NWORDS  = 4;
    localparam int BLOCK_W = WORD_W * NWORDS;
    localparam int NBYTES  = WORD_W / 8;

    localparam int          KC_MUL = 'h9D;
    localparam logic [7:0]  KC_XOR = 8'h5A;

    // Multiply two elements of GF(2^8) modulo x^8+x^4+x^3+x+1.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // Multiplicative inverse as x^254 (maps 0 to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] res;
        logic [7:0] base;
        logic [7:0] e;
        res  = 8'h01;
        base = x;
        e    = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    // AES substitution: inversion followed by the affine map.
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // One keyless AES round: SubBytes, ShiftRows, MixColumns.
    function automatic logic [WORD_W-1:0] aes_round(input logic [WORD_W-1:0] s);
        logic [7:0] sb [NBYTES];
        logic [7:0] sr [NBYTES];
        logic [WORD_W-1:0] o;
        logic [7:0] a0, a1, a2, a3;
        for (int k = 0; k < NBYTES; k++) sb[k] = sbox(s[WORD_W-1-8*k -: 8]);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                sr[4*c+r] = sb[4*((c+r)%4)+r];
        o = '0;
        for (int c = 0; c < 4; c++) begin
            a0 = sr[4*c];   a1 = sr[4*c+1];
            a2 = sr[4*c+2]; a3 = sr[4*c+3];
            o[WORD_W-1-8*(4*c)   -: 8] = gf_mul(a0, 8'h02) ^ gf_mul(a1, 8'h03) ^ a2 ^ a3;
            o[WORD_W-1-8*(4*c+1) -: 8] = a0 ^ gf_mul(a1, 8'h02) ^ gf_mul(a2, 8'h03) ^ a3;
            o[WORD_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ gf_mul(a2, 8'h02) ^ gf_mul(a3, 8'h03);
            o[WORD_W-1-8*(4*c+3) -: 8] = gf_mul(a0, 8'h03) ^ a1 ^ a2 ^ gf_mul(a3, 8'h02);
        end
        return o;
    endfunction

    // Constant for round rnd and branch function fn, computed per byte.
    function automatic logic [WORD_W-1:0] branch_const(input int rnd, input int fn);
        logic [WORD_W-1:0] k;
        for (int j = 0; j < NBYTES; j++)
            k[WORD_W-1-8*j -: 8] = 8'((NBYTES*(4*rnd+fn)+j) * KC_MUL) ^ KC_XOR;
        return k;
    endfunction

endpackage

// File: rtl/wperm_fbox.sv
// Branch function G_FN: one AES round then XOR with the round/branch constant.
// Purely combinational; assumes rnd_i is below the configured round count.
module wperm_fbox #(
    parameter int FN    = 0,
    parameter int CNT_W = 4
) (
    input  logic [wperm_pkg::WORD_W-1:0] x_i,
    input  logic [CNT_W-1:0]             rnd_i,
    output logic [wperm_pkg::WORD_W-1:0] y_o
);
    import wperm_pkg::*;

    // Round transform plus constant addition.
    always_comb begin
        y_o = aes_round(x_i) ^ branch_const(int'(rnd_i), FN);
    end

endmodule

// File: rtl/wperm_round.sv
// One full round of the four-branch structure, all four branches chained
// combinationally. Word 0 (A) is the most significant 128 bits.
module wperm_round #(
    parameter int CNT_W = 4
) (
    input  logic [wperm_pkg::BLOCK_W-1:0] state_i,
    input  logic [CNT_W-1:0]              rnd_i,
    output logic [wperm_pkg::BLOCK_W-1:0] state_o
);
    import wperm_pkg::*;

    logic [WORD_W-1:0] w  [NWORDS];
    logic [WORD_W-1:0] fx [NWORDS];
    logic [WORD_W-1:0] fy [NWORDS];

    // Branch k uses function (k+2) mod 4; its input is the word opposite it
    // mixed with the previous branch output, so updates run A, B, C, D.
    for (genvar k = 0; k < NWORDS; k++) begin : g_branch
        assign w[k] = state_i[BLOCK_W-1-WORD_W*k -: WORD_W];
        if (k == 0) begin : g_head
            assign fx[k] = w[NWORDS-1];
        end else begin : g_link
            assign fx[k] = w[NWORDS-1-k] ^ fy[k-1];
        end
        wperm_fbox #(.FN((k + 2) % 4), .CNT_W(CNT_W)) u_fbox (
            .x_i   (fx[k]),
            .rnd_i (rnd_i),
            .y_o   (fy[k])
        );
        assign state_o[BLOCK_W-1-WORD_W*k -: WORD_W] = w[k] ^ fy[k];
    end

endmodule

// File: rtl/wperm_ctrl.sv
// Round sequencer: accepts start when idle, counts NUM_ROUNDS steps,
// then pulses done for one cycle. Start while busy is ignored.
module wperm_ctrl #(
    parameter int NUM_ROUNDS = 15,
    parameter int CNT_W      = $clog2(NUM_ROUNDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic [CNT_W-1:0] rnd_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

    // Accept only when idle; step on every busy cycle.
    assign load_o = start_i & ~busy_o;
    assign step_o = busy_o;

    // Busy flag, round counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            rnd_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                busy_o <= 1'b1;
                rnd_o  <= '0;
            end else if (busy_o) begin
                if (rnd_o == LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                    rnd_o  <= '0;
                end else begin
                    rnd_o <= rnd_o + 1'b1;
                end
            end
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_last_round_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rnd_o == LAST) |=> (done_o && !busy_o));
    a_r7_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && rnd_o != LAST) |=> (busy_o && rnd_o == CNT_W'($past(rnd_o) + 1'b1)));
    a_r5_fresh_run: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && rnd_o == '0));
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/wide_perm_core.sv
// Top of the 512-bit iterative permutation: state register, sequencer and
// one-round datapath. data_o is the live state; valid when done_o pulses.
module wide_perm_core #(
    parameter int NUM_ROUNDS = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [511:0] data_i,
    output logic [511:0] data_o,
    output logic         busy_o,
    output logic         done_o
);
    import wperm_pkg::*;

    localparam int CNT_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;

    logic               load;
    logic               step;
    logic [CNT_W-1:0]   rnd;
    logic [BLOCK_W-1:0] state_q;
    logic [BLOCK_W-1:0] state_next;

    wperm_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .rnd_o   (rnd),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    wperm_round #(.CNT_W(CNT_W)) u_round (
        .state_i (state_q),
        .rnd_i   (rnd),
        .state_o (state_next)
    );

    // State register: load on accepted start, advance one round while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= '0;
        else if (load) state_q <= data_i;
        else if (step) state_q <= state_next;
    end

    assign data_o = state_q;

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(data_o));
    a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (data_o == $past(data_i)));

endmodule

// File: tb/wide_perm_core_tb.sv
// Scoreboard bench: the driver pushes model results, the monitor checks them on done.
module wide_perm_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 15;
    localparam int LATENCY    = ROUNDS + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [511:0] data_i = '0;
    logic [511:0] data_o;
    logic         busy_o;
    logic         done_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [511:0] exp_q [$];
    int           t0_q  [$];
    logic [511:0] last_exp = '0;
    logic         prev_done = 1'b0;
    logic [7:0]   sbt [256];

    wide_perm_core u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .data_i  (data_i),
        .data_o  (data_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= t;
            t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
        end
        return p;
    endfunction

    // Build the S-box by searching for each inverse, then the affine map per bit.
    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            sbt[x] = s;
        end
    end

    function automatic logic [127:0] gfun(input int k, input int r, input logic [127:0] x);
        logic [7:0] m [4][4];
        logic [7:0] n [4][4];
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 4; w++)
                m[w][c] = x[127-8*(4*c+w) -: 8];
        for (int w = 0; w < 4; w++)
            for (int c = 0; c < 4; c++)
                n[w][c] = sbt[m[w][(c+w)%4]];
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 4; w++) begin
                logic [7:0] v;
                v = mul(n[w][c], 2) ^ mul(n[(w+1)%4][c], 3) ^ n[(w+2)%4][c] ^ n[(w+3)%4][c];
                o[127-8*(4*c+w) -: 8] = v ^ (8'((16*(4*r+k)+4*c+w) * 157) ^ 8'h5A);
            end
        return o;
    endfunction

    function automatic logic [511:0] model(input logic [511:0] v);
        logic [127:0] a, b, c, d, t, u;
        {a, b, c, d} = v;
        for (int r = 0; r < ROUNDS; r++) begin
            t = gfun(2, r, d);
            b = b ^ gfun(3, r, c ^ t);
            u = gfun(0, r, b);
            d = d ^ gfun(1, r, a ^ u);
            c = c ^ u;
            a = a ^ t;
        end
        return {a, b, c, d};
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Driver: start pulse; when accept is set, the model result is queued.
    task automatic drive(input logic [511:0] v, input bit accept);
        @(negedge clk);
        start_i = 1'b1;
        data_i  = v;
        if (accept) begin
            exp_q.push_back(model(v));
            t0_q.push_back(cyc);
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Monitor: compare on every done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(done_o && prev_done), "R6 done width", 512'(done_o), 512'(0));
            if (done_o) begin
                check(!busy_o, "R6 done while busy", 512'(busy_o), 512'(0));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", 512'(1), 512'(0));
                end else begin
                    logic [511:0] e;
                    int t0;
                    e  = exp_q.pop_front();
                    t0 = t0_q.pop_front();
                    last_exp = e;
                    check(data_o == e, "R2 R3 R4 result", data_o, e);
                    check(cyc - t0 == LATENCY, "R5 latency", 512'(cyc - t0), 512'(LATENCY));
                end
            end
        end
        prev_done = done_o;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(data_o == '0 && !busy_o && !done_o, "R1 reset state",
              {data_o[509:0], busy_o, done_o}, '0);

        drive('0, 1'b1);
        check(busy_o == 1'b1, "R5 busy after accept", 512'(busy_o), 512'(1));
        drain();
        drive({512{1'b1}}, 1'b1);
        repeat (ROUNDS - 2) @(negedge clk);
        check(busy_o && !done_o, "R5 busy in last round", 512'({busy_o, done_o}), 512'(2));
        drain();
        drive({128'h0, 128'h1, {4{32'hDEADBEEF}}, 128'hFFFF_0000_FFFF_0000_0123_4567_89AB_CDEF}, 1'b1);
        drain();

        // R8: output holds after done.
        repeat (6) @(negedge clk);
        check(data_o == last_exp, "R8 hold after done", data_o, last_exp);

        // R7: a mid-run start must be ignored.
        drive({16{32'h0F1E2D3C}}, 1'b1);
        repeat (4) @(negedge clk);
        drive({16{32'hA5A5A5A5}}, 1'b0);
        check(busy_o == 1'b1, "R7 still busy", 512'(busy_o), 512'(1));
        drain();
        @(negedge clk);
        check(data_o == last_exp && !busy_o, "R7 ignored start", data_o, last_exp);

        // R9: a start in the done cycle begins a new run.
        drive({8{64'h0123_4567_89AB_CDEF}}, 1'b1);
        while (!done_o) @(negedge clk);
        start_i = 1'b1;
        data_i  = {16{32'h13579BDF}};
        exp_q.push_back(model(data_i));
        t0_q.push_back(cyc);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 start in done cycle", 512'(busy_o), 512'(1));
        drain();

        for (int i = 0; i < 5; i++) begin
            logic [511:0] v;
            for (int j = 0; j < 16; j++) v[32*j +: 32] = $urandom();
            drive(v, 1'b1);
            drain();
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 missing done", 512'(exp_q.size()), 512'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule